// File: doc/BRIEF.md
# SPI master chip-select hold controller

This block is the transmit side of an SPI master with a one-word holding register, an 8-bit shift register and four active-low select lines. The host writes a byte together with a 4-bit select code. The byte moves into the shift register when the shifter is free, and the empty flag then tells the host it may write the next byte. The block generates SCK in mode 0 (idle low, MISO sampled on the rising edge, MOSI changed on the falling edge, MSB first) and collects the received byte.

The main job of the block is to decide whether the active select line is released between back-to-back words. Three things decide it. The first is whether the next byte for the same select is already waiting when the inter-word delay has run out. The second is a per-select option that keeps the line low after a word. The third is a one-shot last-word request, which forces the release after the word written next.

A decode mode puts the select code itself on the four lines, so that an external 1-of-n decoder can address up to 15 slaves. In this mode the all-ones code means that no slave is selected.

Top module: `spi_cs_hold_master`

## Requirements
- R1: A write (`wrEn` high at a clock edge) is taken only while `txEmpty` is 1. A write presented while the holding register is full is dropped, and its byte is never shifted out.
- R2: `txEmpty` is 1 after reset. It drops to 0 in the cycle after an accepted write. It returns to 1 in the cycle after the held byte moves into the shift register, which happens while the previous word's select handling allows a start, and well before that word ends.
- R3: SCK is low except while shifting. The effective divider is `clkDiv`, with values below 2 treated as 2. Each bit lasts that many clocks: SCK is low for the first ceil(div/2) clocks and high for the rest. The 8 bits go out MSB first on MOSI. MISO is sampled at the SCK rising edge. `rxData` holds the received byte, and `rxValid` pulses for one clock when the word ends.
- R4: If a byte for the same select code is waiting when the inter-word delay ends, and its word did not carry a last-word request, the select stays low and the next word starts in the following clock.
- R5: If the hold option of the select is off and no byte is waiting at the end of the delay, the select goes high.
- R6: `holdCfg[k]` enables the hold option for select codes whose two low bits equal k. With the hold option on, the line stays low with no byte waiting. A later byte for the same code starts without any release. A byte for a different code releases the line first.
- R7: A `lastSet` pulse raises `lastPending`. The next accepted write captures the request with its byte. When that word's delay ends, the select goes high even if the hold option is on, and `lastPending` clears at that moment unless `lastSet` is pulsed again in the same clock.
- R8: After the last bit of each word there are `xferGap`+1 clocks with SCK low before the next decision. Across a kept select, the spacing between rising SCK edges is therefore div+`xferGap`+1 clocks.
- R9: Every release keeps all select lines high for at least one SCK period (div clocks) before any select is asserted again.
- R10: Direct mode (`decodeMode`=0): code k in 0..3 drives `csN[k]` low and the other lines high, and codes 4..15 assert no line. Decode mode (`decodeMode`=1): while selected, `csN` equals the select code. In both modes every line is high when nothing is selected.
- R11: After reset: `csN`=4'b1111, `sck`=0, `mosi`=0, `txEmpty`=1, `lastPending`=0, `rxValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the holding register |
| wrData | input | 8 | Byte to transmit |
| wrSel | input | 4 | Select code for this byte |
| lastSet | input | 1 | Pulse: the next written byte ends the select session |
| holdCfg | input | 4 | Per-select keep-asserted option |
| decodeMode | input | 1 | 1: select lines carry a binary code |
| clkDiv | input | 8 | SCK period in system clocks (minimum 2) |
| xferGap | input | 8 | Extra idle clocks after each word |
| txEmpty | output | 1 | Holding register may be written |
| lastPending | output | 1 | Last-word request not yet consumed |
| sck | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 4 | Active-low select lines or decode code |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | One-clock pulse when a word ends |

## Verification
The bench goes after several corner cases, each with a distinct wrong behaviour. A second byte for the same select written during the first word must not cause a release; a design that decides at the end of the word instead of at the end of the delay would lift the line. A select kept low by the hold option must drop for a full SCK period before a different select is driven; a design that hands over directly would show a zero-length high gap. A last-word request must override the hold option and then clear; a design that does not capture it with the byte would release one word early or never. A write into a full holding register and a divider of 2, where the rising-edge sample and the word end fall close together, would show up as a lost or corrupted byte.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_RECOVER
  } ctrlState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;   // latch host byte into holding register
    logic load;      // move holding register into shifter
    logic shiftOut;  // advance to next bit
    logic sample;    // take MISO (SCK rising edge)
    logic finish;    // word complete
    logic active;    // shifting in progress
  } dpStrobe_t;

endpackage

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl
  import spi_cs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_CS = 4,
  parameter int DIV_W  = 8,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [NUM_CS-1:0] wrSel,
  input  logic              lastSet,
  input  logic [NUM_CS-1:0] holdCfg,
  input  logic              decodeMode,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [GAP_W-1:0]  xferGap,
  output dpStrobe_t         strobe,
  output logic              sck,
  output logic [NUM_CS-1:0] csN,
  output logic              txEmpty,
  output logic              lastPending
);

  localparam int SEL_W = NUM_CS;
  localparam int BIT_W = $clog2(DATA_W);
  localparam int CFG_W = $clog2(NUM_CS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [DIV_W-1:0] MIN_DIV  = DIV_W'(2);

  ctrlState_t state;
  logic [DIV_W-1:0] cnt;
  logic [BIT_W-1:0] bitIdx;
  logic [GAP_W-1:0] gapCnt;
  logic             holdFull;
  logic [SEL_W-1:0] holdSel;
  logic             holdLast;
  logic [SEL_W-1:0] curSel;
  logic             curLast;
  logic             csActive;
  logic             lastFlag;

  logic [DIV_W-1:0] divEff;
  logic [DIV_W-1:0] lowLen;
  logic periodEnd, sameSel, gapDone;
  logic idleStart, gapStart, startWord, idleSwitch;
  logic gapKeep, gapRelease, acceptWr, wordDone;

  always_comb begin
    divEff     = (clkDiv < MIN_DIV) ? MIN_DIV : clkDiv;
    lowLen     = divEff - (divEff >> 1);
    periodEnd  = (cnt == divEff - DIV_W'(1));
    sameSel    = (holdSel == curSel);
    gapDone    = (gapCnt == xferGap);
    acceptWr   = wrEn && !holdFull;
    idleStart  = (state == ST_IDLE) && holdFull && (!csActive || sameSel);
    gapStart   = (state == ST_GAP) && gapDone && holdFull && sameSel && !curLast;
    startWord  = idleStart || gapStart;
    idleSwitch = (state == ST_IDLE) && holdFull && csActive && !sameSel;
    gapKeep    = (state == ST_GAP) && gapDone && !startWord && !curLast &&
                 !holdFull && holdCfg[curSel[CFG_W-1:0]];
    gapRelease = (state == ST_GAP) && gapDone && !startWord && !gapKeep;
    wordDone   = (state == ST_SHIFT) && periodEnd && (bitIdx == LAST_BIT);
  end

  // Holding register bookkeeping and last-word request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      holdSel  <= '1;
      holdLast <= 1'b0;
      lastFlag <= 1'b0;
    end else begin
      if (startWord) begin
        holdFull <= 1'b0;
      end else if (acceptWr) begin
        holdFull <= 1'b1;
        holdSel  <= wrSel;
        holdLast <= lastFlag || lastSet;
      end
      if (lastSet) begin
        lastFlag <= 1'b1;
      end else if (gapRelease && curLast) begin
        lastFlag <= 1'b0;
      end
    end
  end

  // Sequencer: shifting, inter-word delay, release recovery
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bitIdx   <= '0;
      gapCnt   <= '0;
      curSel   <= '1;
      curLast  <= 1'b0;
      csActive <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startWord) begin
            state    <= ST_SHIFT;
            cnt      <= '0;
            bitIdx   <= '0;
            curSel   <= holdSel;
            curLast  <= holdLast;
            csActive <= 1'b1;
          end else if (idleSwitch) begin
            csActive <= 1'b0;
            state    <= ST_RECOVER;
            cnt      <= '0;
          end
        end
        ST_SHIFT: begin
          if (periodEnd) begin
            cnt <= '0;
            if (bitIdx == LAST_BIT) begin
              state  <= ST_GAP;
              gapCnt <= '0;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (startWord) begin
            state   <= ST_SHIFT;
            cnt     <= '0;
            bitIdx  <= '0;
            curLast <= holdLast;
          end else if (gapKeep) begin
            state <= ST_IDLE;
          end else if (gapRelease) begin
            csActive <= 1'b0;
            state    <= ST_RECOVER;
            cnt      <= '0;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        ST_RECOVER: begin
          if (periodEnd) begin
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Select line encoding
  logic [NUM_CS-1:0] directN;
  for (genvar i = 0; i < NUM_CS; i++) begin : g_direct
    assign directN[i] = !(csActive && (curSel == SEL_W'(i)));
  end

  always_comb begin
    if (decodeMode) begin
      csN = csActive ? curSel : '1;
    end else begin
      csN = directN;
    end
    sck             = (state == ST_SHIFT) && (cnt >= lowLen);
    txEmpty         = !holdFull;
    lastPending     = lastFlag;
    strobe.capture  = acceptWr;
    strobe.load     = startWord;
    strobe.shiftOut = (state == ST_SHIFT) && periodEnd && (bitIdx != LAST_BIT);
    strobe.sample   = (state == ST_SHIFT) && (cnt == lowLen - DIV_W'(1));
    strobe.finish   = wordDone;
    strobe.active   = (state == ST_SHIFT);
  end

  // R1: a write into a full holding register leaves it untouched
  a_r1_full_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (holdFull && wrEn && !startWord) |=> (holdFull && $stable(holdSel)));

  // R3: SCK only toggles while a select session is open
  a_r3_sck_needs_select: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> csActive);

  // R4: a same-select byte ready at the decision point keeps the line low
  a_r4_same_select_continues: assert property (@(posedge clk) disable iff (!rstN)
    gapStart |=> (csActive && state == ST_SHIFT));

  // R6: a kept select stays low while nothing is waiting
  a_r6_hold_persists: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && csActive && !holdFull) |=> csActive);

  // R7: a word carrying the last-word request always ends in a release
  a_r7_last_forces_release: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP && gapDone && curLast) |=> !csActive);

  // R9: the asserted select never changes to another code directly
  a_r9_no_direct_handover: assert property (@(posedge clk) disable iff (!rstN)
    (csActive && $past(csActive)) |-> (curSel == $past(curSel)));

endmodule

// File: rtl/spi_cs_dpath.sv
module spi_cs_dpath
  import spi_cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid
);

  logic [DATA_W-1:0] holdData;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData <= '0;
      txShift  <= '0;
      rxShift  <= '0;
      rxData   <= '0;
      rxValid  <= 1'b0;
    end else begin
      if (strobe.capture) begin
        holdData <= wrData;
      end
      if (strobe.load) begin
        txShift <= holdData;
      end else if (strobe.shiftOut) begin
        txShift <= {txShift[DATA_W-2:0], 1'b0};
      end
      if (strobe.sample) begin
        rxShift <= {rxShift[DATA_W-2:0], miso};
      end
      rxValid <= strobe.finish;
      if (strobe.finish) begin
        rxData <= rxShift;
      end
    end
  end

  assign mosi = strobe.active ? txShift[DATA_W-1] : 1'b0;

  // R3: the received-word pulse lasts exactly one clock
  a_r3_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R3: MOSI only moves at a bit boundary or word start/end
  a_r3_mosi_holds: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.active && !strobe.shiftOut && !strobe.load && !strobe.finish)
      |=> $stable(mosi));

endmodule

// File: rtl/spi_cs_hold_master.sv
module spi_cs_hold_master
  import spi_cs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_CS = 4,
  parameter int DIV_W  = 8,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_CS-1:0] wrSel,
  input  logic              lastSet,
  input  logic [NUM_CS-1:0] holdCfg,
  input  logic              decodeMode,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [GAP_W-1:0]  xferGap,
  output logic              txEmpty,
  output logic              lastPending,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] csN,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid
);

  dpStrobe_t strobe;

  spi_cs_ctrl #(
    .DATA_W(DATA_W), .NUM_CS(NUM_CS), .DIV_W(DIV_W), .GAP_W(GAP_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .lastSet    (lastSet),
    .holdCfg    (holdCfg),
    .decodeMode (decodeMode),
    .clkDiv     (clkDiv),
    .xferGap    (xferGap),
    .strobe     (strobe),
    .sck        (sck),
    .csN        (csN),
    .txEmpty    (txEmpty),
    .lastPending(lastPending)
  );

  spi_cs_dpath #(
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .miso   (miso),
    .mosi   (mosi),
    .rxData (rxData),
    .rxValid(rxValid)
  );

endmodule

// File: tb/spi_cs_hold_master_test.sv
`timescale 1ns/1ps
module spi_cs_hold_master_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [3:0] wrSel = '0;
  logic lastSet = 1'b0;
  logic [3:0] holdCfg = '0;
  logic decodeMode = 1'b0;
  logic [7:0] clkDiv = 8'd4;
  logic [7:0] xferGap = 8'd2;
  logic txEmpty, lastPending, sck, mosi, miso;
  logic [3:0] csN;
  logic [7:0] rxData;
  logic rxValid;

  assign miso = ~mosi;  // slave echoes the inverted bit

  always #10 clk = ~clk;  // 50 MHz

  spi_cs_hold_master uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .wrSel(wrSel),
    .lastSet(lastSet), .holdCfg(holdCfg), .decodeMode(decodeMode),
    .clkDiv(clkDiv), .xferGap(xferGap), .txEmpty(txEmpty),
    .lastPending(lastPending), .sck(sck), .mosi(mosi), .miso(miso),
    .csN(csN), .rxData(rxData), .rxValid(rxValid)
  );

  int nChecks = 0;
  int nErrors = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mState;  // 0 idle, 1 shifting, 2 delay, 3 recovery
  int mCnt, mBit, mGap;
  int mHoldFull, mHoldSel, mHoldLast, mHoldData;
  int mCurSel, mCurLast, mCs, mLast;
  int mTx, mRx, mRxData, mRxValid;

  function automatic int effDiv();
    return (clkDiv < 2) ? 2 : int'(clkDiv);
  endfunction

  always @(posedge clk) begin
    int dv, lowL;
    bit pEnd, same, gDone, go, idleSw, keep, rel, acc, relLast;
    if (!rstN) begin
      mState = 0; mCnt = 0; mBit = 0; mGap = 0;
      mHoldFull = 0; mHoldSel = 15; mHoldLast = 0; mHoldData = 0;
      mCurSel = 15; mCurLast = 0; mCs = 0; mLast = 0;
      mTx = 0; mRx = 0; mRxData = 0; mRxValid = 0;
    end else begin
      dv     = effDiv();
      lowL   = dv - dv / 2;
      pEnd   = (mCnt == dv - 1);
      same   = (mHoldSel == mCurSel);
      gDone  = (mGap == int'(xferGap));
      go     = mHoldFull && ((mState == 0 && (!mCs || same)) ||
                             (mState == 2 && gDone && same && !mCurLast));
      idleSw = (mState == 0) && mHoldFull && mCs && !same;
      keep   = (mState == 2) && gDone && !go && !mCurLast && !mHoldFull &&
               holdCfg[mCurSel % 4];
      rel    = (mState == 2) && gDone && !go && !keep;
      relLast = rel && mCurLast;
      acc    = wrEn && !mHoldFull;
      mRxValid = 0;
      if (mState == 1 && mCnt == lowL - 1)
        mRx = ((mRx << 1) | (1 - ((mTx >> 7) & 1))) & 255;
      case (mState)
        0: begin
          if (go) begin
            mState = 1; mCnt = 0; mBit = 0; mCurSel = mHoldSel;
            mCurLast = mHoldLast; mCs = 1; mTx = mHoldData;
          end else if (idleSw) begin
            mCs = 0; mState = 3; mCnt = 0;
          end
        end
        1: begin
          if (pEnd) begin
            mCnt = 0;
            if (mBit == 7) begin
              mState = 2; mGap = 0; mRxValid = 1; mRxData = mRx;
            end else begin
              mBit++; mTx = (mTx << 1) & 255;
            end
          end else mCnt++;
        end
        2: begin
          if (go) begin
            mState = 1; mCnt = 0; mBit = 0; mCurLast = mHoldLast; mTx = mHoldData;
          end else if (keep) mState = 0;
          else if (rel) begin
            mCs = 0; mState = 3; mCnt = 0;
          end else mGap++;
        end
        default: begin
          if (pEnd) mState = 0; else mCnt++;
        end
      endcase
      if (go) mHoldFull = 0;
      else if (acc) begin
        mHoldFull = 1; mHoldSel = wrSel; mHoldData = wrData;
        mHoldLast = (mLast || lastSet) ? 1 : 0;
      end
      if (lastSet) mLast = 1;
      else if (relLast) mLast = 0;
    end
  end

  // ---------------- per-clock comparison and event tracking ----------------
  int cycle = 0, releaseCnt = 0, highRun = 0, lastHighRun = 0;
  int lastRise = -1, maxRiseGap = 0, words = 0, lastRx = 0;
  logic [3:0] prevCs = 4'hF;
  logic prevSck = 1'b0;

  always @(negedge clk) begin
    int dv, expCs, expSck, expMosi;
    if (rstN) begin
      dv = effDiv();
      if (!mCs) expCs = 15;
      else if (decodeMode) expCs = mCurSel;
      else expCs = (mCurSel < 4) ? (~(1 << mCurSel) & 15) : 15;
      expSck  = (mState == 1 && mCnt >= dv - dv / 2) ? 1 : 0;
      expMosi = (mState == 1) ? ((mTx >> 7) & 1) : 0;
      chk(int'(csN) == expCs, "R10 csN", csN, expCs);
      chk(int'(sck) == expSck, "R3 R8 sck", sck, expSck);
      chk(int'(mosi) == expMosi, "R3 mosi", mosi, expMosi);
      chk(int'(txEmpty) == 1 - mHoldFull, "R2 txEmpty", txEmpty, 1 - mHoldFull);
      chk(int'(lastPending) == mLast, "R7 lastPending", lastPending, mLast);
      chk(int'(rxValid) == mRxValid, "R3 rxValid", rxValid, mRxValid);
      if (mRxValid) chk(int'(rxData) == mRxData, "R3 rxData", rxData, mRxData);
      cycle++;
      if (csN == 4'hF) highRun++;
      else begin
        if (prevCs == 4'hF) lastHighRun = highRun;
        highRun = 0;
      end
      if (prevCs != 4'hF && csN == 4'hF) releaseCnt++;
      if (sck && !prevSck) begin
        if (lastRise >= 0 && cycle - lastRise > maxRiseGap) maxRiseGap = cycle - lastRise;
        lastRise = cycle;
      end
      if (rxValid) begin
        words++;
        lastRx = rxData;
      end
      prevCs = csN;
      prevSck = sck;
    end
  end

  // ---------------- watchdog ----------------
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      nErrors++;
      $display("FAIL watchdog: actual %0d expected below 150000", wd);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [3:0] sel, input logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitEmpty();
    while (!txEmpty) @(negedge clk);
  endtask

  initial begin
    int w0, r0;
    repeat (3) @(negedge clk);
    // R11: reset values
    chk(csN == 4'hF, "R11 csN", csN, 15);
    chk(sck == 1'b0, "R11 sck", sck, 0);
    chk(mosi == 1'b0, "R11 mosi", mosi, 0);
    chk(txEmpty == 1'b1, "R11 txEmpty", txEmpty, 1);
    chk(lastPending == 1'b0, "R11 lastPending", lastPending, 0);
    chk(rxValid == 1'b0, "R11 rxValid", rxValid, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 / R2: second write lands while the register is full
    w0 = words;
    wr(4'd0, 8'hA5);
    chk(txEmpty == 1'b0, "R2 empty drops after write", txEmpty, 0);
    wrEn = 1'b1; wrSel = 4'd0; wrData = 8'h3C;
    @(negedge clk);
    wrEn = 1'b0;
    repeat (80) @(negedge clk);
    chk(words - w0 == 1, "R1 dropped write not sent", words - w0, 1);
    chk(lastRx == 8'h5A, "R1 R3 received byte", lastRx, 8'h5A);
    chk(csN == 4'hF, "R5 release without hold", csN, 15);

    // R4: back-to-back on the same select, hold off
    r0 = releaseCnt; w0 = words;
    wr(4'd2, 8'h11);
    waitEmpty();
    wr(4'd2, 8'h22);
    repeat (100) @(negedge clk);
    chk(releaseCnt - r0 == 1, "R4 single release over two words", releaseCnt - r0, 1);
    chk(words - w0 == 2, "R4 both words sent", words - w0, 2);

    // R6: hold option keeps select 1 low
    holdCfg = 4'b0010;
    wr(4'd1, 8'h33);
    repeat (100) @(negedge clk);
    chk(csN == 4'b1101, "R6 select held after word", csN, 4'b1101);
    r0 = releaseCnt;
    wr(4'd1, 8'h44);
    repeat (100) @(negedge clk);
    chk(csN == 4'b1101, "R6 select still held", csN, 4'b1101);
    chk(releaseCnt == r0, "R6 no release on same select", releaseCnt - r0, 0);

    // R9: switch to another select from a held one
    clkDiv = 8'd6;
    wr(4'd2, 8'h55);
    repeat (120) @(negedge clk);
    chk(lastHighRun >= 6, "R9 high gap before new select", lastHighRun, 6);
    chk(releaseCnt - r0 == 2, "R6 switch releases held select", releaseCnt - r0, 2);

    // R7: last-word request overrides hold
    clkDiv = 8'd4;
    @(negedge clk); lastSet = 1'b1;
    @(negedge clk); lastSet = 1'b0;
    chk(lastPending == 1'b1, "R7 request pending", lastPending, 1);
    wr(4'd1, 8'h66);
    repeat (100) @(negedge clk);
    chk(csN == 4'hF, "R7 released despite hold", csN, 15);
    chk(lastPending == 1'b0, "R7 request cleared", lastPending, 0);

    // R8: inter-word delay with the minimum divider
    holdCfg = 4'b0000;
    clkDiv = 8'd1;   // treated as 2
    xferGap = 8'd20;
    @(negedge clk);
    lastRise = -1; maxRiseGap = 0;
    wr(4'd0, 8'h77);
    waitEmpty();
    wr(4'd0, 8'h88);
    repeat (80) @(negedge clk);
    chk(maxRiseGap == 23, "R8 rise spacing across delay", maxRiseGap, 23);
    chk(lastRx == 8'h77, "R3 second word at div 2", lastRx, 8'h77);

    // R10: decode mode and out-of-range direct codes
    clkDiv = 8'd4; xferGap = 8'd2;
    decodeMode = 1'b1;
    wr(4'd9, 8'h99);
    while (!sck) @(negedge clk);
    chk(csN == 4'd9, "R10 decode code on lines", csN, 9);
    repeat (80) @(negedge clk);
    chk(csN == 4'hF, "R10 decode idle code", csN, 15);
    decodeMode = 1'b0;
    wr(4'd6, 8'h12);
    while (!sck) @(negedge clk);
    chk(csN == 4'hF, "R10 direct code 6 selects none", csN, 15);
    repeat (60) @(negedge clk);
    chk(lastRx == 8'hED, "R3 byte with no select", lastRx, 8'hED);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule